// File: doc/BRIEF.md
# Data-Rate Prescaler with Timeout Scaling

This block sets the bit rate of a token-passing network controller. It also keeps that controller's protocol timeouts at a fixed length in bit times. It runs from a single fast system clock. With the default parameters that clock stands for the 80 MHz top of a 20 MHz crystal after multiplication. Real clock multiplication is not built. A 3-bit rate code selects one of seven data rates, from 10 Mbps (code 0) down to 156.25 kbps (code 6).

Internally the code is split into two fields:
- a clock-multiplier step: ×4, ×2 or ×1 on the 20 MHz reference;
- a prescale shift: a divide-by-8 base that grows to divide-by-16 through divide-by-128.

Codes 0 to 2 use the multiplier step with a divide-by-8 prescaler. Codes 3 to 6 stay at ×1 and raise the prescaler. The block produces a one-cycle `bit_tick` enable at the selected rate and a one-hot timeout multiplier. That multiplier lets other timers scale their windows in the same way.

An idle-line timer counts a fixed number of bit ticks and is restarted by line activity. This keeps the idle timeout at the same number of bit times at every rate. Its length in time therefore grows by the multiplier: about 20.5 µs at the fastest rate and about 1.3 ms at the slowest. A change of rate code never shortens or stretches a bit period that is already running. The new code is taken only at a tick boundary.

Top module: `rate_prescaler`

## Requirements
- R1: While reset is asserted, `bit_tick` and `idle_expire` are 0, `active_rate` is 6 and `timeout_mult` is 7'h40.
- R2: For a rate code c from 0 to 6, successive `bit_tick` pulses are BASE_DIV·2^c clock cycles apart. With BASE_DIV=8 this gives 8 to 512 cycles, which at an 80 MHz clock is 10 Mbps down to 156.25 kbps.
- R3: Rate code 7 behaves exactly like code 6: it gives the same tick period, `active_rate` reads 6 and `timeout_mult` reads 7'h40.
- R4: `bit_tick` is high for exactly one clock cycle per bit period. BASE_DIV must be at least 2.
- R5: The period that starts after a tick uses the rate code present on `rate_sel` during the tick cycle. A code change at any other time alters neither the running period nor `active_rate`.
- R6: `timeout_mult` is one-hot, with its single set bit at position `active_rate`, so it equals 2^`active_rate`. `active_rate` is the code (after clamping) of the period that is running.
- R7: With `line_active` low, `idle_expire` pulses in the cycle after the IDLE_TICKS-th tick counted since the last cycle in which `line_active` was high. A tick in a cycle with `line_active` high is not counted, and `line_active` restarts the count.
- R8: `idle_expire` is a single-cycle pulse and fires at most once for each stretch of idle line.
- R9: The idle timeout measured in clock cycles from the release of `line_active` lies between (IDLE_TICKS−1)·P+1 and IDLE_TICKS·P, where P is the tick period. It therefore scales with `timeout_mult`.
- R10: After reset is released, the first tick comes after BASE_DIV·64−1 rising edges, which is one period of the slowest rate. Only after that tick does the divider adopt `rate_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 3 | Rate code, 0 = fastest, 6 = slowest, 7 treated as 6 |
| line_active | input | 1 | High in cycles with activity seen on the line |
| bit_tick | output | 1 | One-cycle enable at the selected bit rate |
| active_rate | output | 3 | Clamped rate code of the running period |
| timeout_mult | output | 7 | One-hot timeout scaling factor, 2^active_rate |
| idle_expire | output | 1 | One-cycle pulse when the idle-line timeout runs out |

## Verification
The bench builds the block with BASE_DIV=2 and IDLE_TICKS=5. The slowest tick period is then 128 cycles and an idle timeout is at most 640 cycles. This small setting lets the bench sweep all eight rate codes and measure every tick interval cycle by cycle. It also lets it run complete idle timeouts at the fastest, a middle and the slowest rate within a short run. Code changes are placed both on and between tick boundaries, so the period-holding rule is observed from both sides.

// File: rtl/rate_pkg.sv
`timescale 1ns/1ps
package rate_pkg;
  localparam int NUM_RATES   = 7;
  localparam int RATE_W      = 3;
  localparam int MULT_W      = NUM_RATES;
  localparam int CKMUL_W     = 2;
  localparam int CKMUL_STEPS = 2;
  localparam int PSH_W       = 3;
  localparam logic [RATE_W-1:0] RATE_SLOWEST = RATE_W'(NUM_RATES - 1);

  typedef struct packed {
    logic [CKMUL_W-1:0] ckmul;   // internal clock = reference * 2^ckmul
    logic [PSH_W-1:0]   pshift;  // prescaler = base divide << pshift
  } rate_cfg_t;
endpackage

// File: rtl/rate_decode.sv
`timescale 1ns/1ps
module rate_decode
  import rate_pkg::*;
(
  input  logic [RATE_W-1:0] code_i,
  output logic [RATE_W-1:0] idx_o,
  output rate_cfg_t         cfg_o
);
  always_comb begin
    idx_o = (code_i > RATE_SLOWEST) ? RATE_SLOWEST : code_i;
    if (idx_o <= RATE_W'(CKMUL_STEPS)) begin
      cfg_o.ckmul  = CKMUL_W'(RATE_W'(CKMUL_STEPS) - idx_o);
      cfg_o.pshift = '0;
    end else begin
      cfg_o.ckmul  = '0;
      cfg_o.pshift = PSH_W'(idx_o - RATE_W'(CKMUL_STEPS));
    end
  end
endmodule

// File: rtl/rate_divider.sv
`timescale 1ns/1ps
module rate_divider
  import rate_pkg::*;
#(
  parameter int BASE_DIV = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rate_cfg_t         cfg_i,
  input  logic [RATE_W-1:0] idx_i,
  output logic              tick_o,
  output logic [RATE_W-1:0] act_idx_o
);
  localparam int PMAX  = BASE_DIV << (NUM_RATES - 1);
  localparam int CNT_W = $clog2(PMAX);

  logic [CNT_W-1:0]  cnt_q, cnt_d, period_m1;
  logic [RATE_W-1:0] act_q, act_d;
  logic [31:0]       period_w;

  always_comb begin
    period_w  = 32'(BASE_DIV) << (32'(CKMUL_STEPS) - 32'(cfg_i.ckmul) + 32'(cfg_i.pshift));
    period_m1 = CNT_W'(period_w - 32'd1);
  end

  assign tick_o    = (cnt_q == '0);
  assign act_idx_o = act_q;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (tick_o) begin
      cnt_d = period_m1;
      act_d = idx_i;
    end else begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_W'(PMAX - 1);
      act_q <= RATE_SLOWEST;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  // R4: tick never lasts two cycles
  a_r4_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
  // R5: rate only changes across a tick boundary
  a_r5_rate_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_o |=> $stable(act_q));
  // R2: a reload always starts a non-empty period
  a_r2_reload_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cnt_q != '0));
endmodule

// File: rtl/idle_timer.sv
`timescale 1ns/1ps
module idle_timer #(
  parameter int IDLE_TICKS = 205
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic line_active_i,
  output logic expire_o
);
  localparam int IT_W = $clog2(IDLE_TICKS + 1);

  logic [IT_W-1:0] tmr_q, tmr_d;
  logic            exp_q, exp_d;

  always_comb begin
    tmr_d = tmr_q;
    exp_d = 1'b0;
    if (line_active_i) begin
      tmr_d = IT_W'(IDLE_TICKS);
    end else if (tick_i && (tmr_q != '0)) begin
      tmr_d = tmr_q - IT_W'(1);
      exp_d = (tmr_q == IT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= IT_W'(IDLE_TICKS);
      exp_q <= 1'b0;
    end else begin
      tmr_q <= tmr_d;
      exp_q <= exp_d;
    end
  end

  assign expire_o = exp_q;

  // R8: single-cycle expiry pulse
  a_r8_expire_single: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !expire_o);
  // R7: expiry follows a counted tick on an idle line
  a_r7_expire_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |-> ($past(tick_i) && !$past(line_active_i)));
endmodule

// File: rtl/rate_prescaler.sv
`timescale 1ns/1ps
module rate_prescaler
  import rate_pkg::*;
#(
  parameter int BASE_DIV   = 8,
  parameter int IDLE_TICKS = 205
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              line_active,
  output logic              bit_tick,
  output logic [RATE_W-1:0] active_rate,
  output logic [MULT_W-1:0] timeout_mult,
  output logic              idle_expire
);
  logic [RATE_W-1:0] dec_idx;
  rate_cfg_t         dec_cfg;

  rate_decode u_decode (
    .code_i (rate_sel),
    .idx_o  (dec_idx),
    .cfg_o  (dec_cfg)
  );

  rate_divider #(.BASE_DIV(BASE_DIV)) u_divider (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_i     (dec_cfg),
    .idx_i     (dec_idx),
    .tick_o    (bit_tick),
    .act_idx_o (active_rate)
  );

  assign timeout_mult = MULT_W'(1) << active_rate;

  idle_timer #(.IDLE_TICKS(IDLE_TICKS)) u_idle (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_i        (bit_tick),
    .line_active_i (line_active),
    .expire_o      (idle_expire)
  );

  // R3: the running rate never leaves the legal range
  a_r3_rate_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    active_rate <= RATE_SLOWEST);
  // R7: no expiry while the line is active
  a_r7_quiet_when_active: assert property (@(posedge clk) disable iff (!rst_n)
    line_active |=> !idle_expire);
endmodule

// File: tb/test_rate_prescaler.sv
`timescale 1ns/1ps
module test_rate_prescaler;
  localparam int BD   = 2;
  localparam int IDLE = 5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] rate_sel;
  logic       line_active;
  logic       bit_tick;
  logic [2:0] active_rate;
  logic [6:0] timeout_mult;
  logic       idle_expire;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #2.5 clk = ~clk;

  rate_prescaler #(.BASE_DIV(BD), .IDLE_TICKS(IDLE)) i_rate_prescaler (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .line_active(line_active),
    .bit_tick(bit_tick), .active_rate(active_rate),
    .timeout_mult(timeout_mult), .idle_expire(idle_expire)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!bit_tick);
  endtask

  function automatic int period_of(input int code);
    int c;
    c = (code > 6) ? 6 : code;
    return BD << c;
  endfunction

  // Observe one idle stretch starting at the current negedge (line already low)
  task automatic watch_idle(input int limit, output int first_el, output int tk_at,
                            output bit after_tick, output int npulse);
    int el, ntk;
    bit last_tick;
    el = 0; ntk = 0; last_tick = 1'b0;
    first_el = -1; tk_at = -1; after_tick = 1'b0; npulse = 0;
    repeat (limit) begin
      if (idle_expire) begin
        npulse++;
        if (first_el < 0) begin
          first_el = el; tk_at = ntk; after_tick = last_tick;
        end
      end
      last_tick = bit_tick;
      if (bit_tick) ntk++;
      step();
      el++;
    end
  endtask

  task automatic run_idle(input int code);
    int n, p, fe, tk, np;
    bit at;
    p = period_of(code);
    rate_sel = 3'(code);
    wait_tick(n);
    wait_tick(n);
    line_active = 1'b1;
    step();
    line_active = 1'b0;
    watch_idle(3 * IDLE * p, fe, tk, at, np);
    check(tk == IDLE, "R7", "ticks before expiry", tk, IDLE);
    check(at, "R7", "expiry one cycle after tick", int'(at), 1);
    check(np == 1, "R8", "pulses per idle stretch", np, 1);
    check(fe >= (IDLE - 1) * p + 1 && fe <= IDLE * p, "R9", "idle timeout cycles",
          fe, IDLE * p);
    line_active = 1'b1;
  endtask

  initial begin
    int n, sum, p, fe, tk, np;
    bit at;
    rst_n = 1'b0; rate_sel = 3'd0; line_active = 1'b1;
    repeat (4) step();
    // R1 reset state
    check(bit_tick == 1'b0, "R1", "bit_tick in reset", int'(bit_tick), 0);
    check(idle_expire == 1'b0, "R1", "idle_expire in reset", int'(idle_expire), 0);
    check(active_rate == 3'd6, "R1", "active_rate in reset", int'(active_rate), 6);
    check(timeout_mult == 7'h40, "R1", "timeout_mult in reset", int'(timeout_mult), 64);
    rst_n = 1'b1;

    // R10 first period after reset at the slowest rate
    wait_tick(n);
    check(n == (BD << 6) - 1, "R10", "first tick after reset", n, (BD << 6) - 1);
    check(active_rate == 3'd6, "R10", "rate during first period", int'(active_rate), 6);
    wait_tick(n);
    check(n == period_of(0), "R10", "period after first tick", n, period_of(0));

    // R2 / R3 / R6 sweep over all codes, changed at tick boundaries
    for (int code = 0; code < 8; code++) begin
      int cl;
      cl = (code > 6) ? 6 : code;
      rate_sel = 3'(code);
      wait_tick(n);
      check(n == period_of(code), (code == 7) ? "R3" : "R2", "tick period", n,
            period_of(code));
      check(active_rate == 3'(cl), (code == 7) ? "R3" : "R6", "active_rate",
            int'(active_rate), cl);
      check(timeout_mult == 7'(1 << cl), "R6", "timeout_mult", int'(timeout_mult),
            1 << cl);
      step();
      check(bit_tick == 1'b0, "R4", "tick width", int'(bit_tick), 0);
      wait_tick(n);
      check(n + 1 == period_of(code), "R2", "repeat period", n + 1, period_of(code));
    end

    // R5 change mid-period: running slow period is kept
    rate_sel = 3'd6;
    wait_tick(n);
    repeat (10) step();
    rate_sel = 3'd0;
    repeat (3) step();
    check(active_rate == 3'd6, "R5", "rate held mid-period", int'(active_rate), 6);
    check(timeout_mult == 7'h40, "R5", "mult held mid-period", int'(timeout_mult), 64);
    wait_tick(n);
    sum = 13 + n;
    check(sum == period_of(6), "R5", "no runt period", sum, period_of(6));
    wait_tick(n);
    check(n == period_of(0), "R5", "new rate after boundary", n, period_of(0));

    // R5 change between ticks at the fast rate
    step();
    rate_sel = 3'd5;
    step();
    check(bit_tick == 1'b1, "R5", "old period completes", int'(bit_tick), 1);
    wait_tick(n);
    check(n == period_of(5), "R5", "period after change", n, period_of(5));
    check(active_rate == 3'd5, "R6", "active_rate after change", int'(active_rate), 5);

    // R7 / R8 / R9 idle timeout at several rates
    run_idle(0);
    run_idle(3);
    run_idle(6);
    run_idle(7);

    // R7 activity in mid-count restarts the timer
    p = period_of(3);
    rate_sel = 3'd3;
    wait_tick(n);
    line_active = 1'b1;
    step();
    line_active = 1'b0;
    wait_tick(n);
    wait_tick(n);
    wait_tick(n);
    step();
    line_active = 1'b1;
    step();
    line_active = 1'b0;
    watch_idle(3 * IDLE * p, fe, tk, at, np);
    check(tk == IDLE, "R7", "ticks after restart", tk, IDLE);
    check(np == 1, "R8", "pulses after restart", np, 1);
    line_active = 1'b1;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule